// File: doc/BRIEF.md
# Page Write Collector and Programming Timer

This block gathers the data bytes of one page write into a local page buffer. It commits them to the memory array only after chip select has closed the sequence, and then holds a busy interval whose length stands for the cell programming time. A write sequence opens with a start strobe that carries the first target address. Each incoming byte comes with a grant bit from the protection arbiter. Only the low offset bits of the address advance from byte to byte. A long burst therefore circles inside its page, and a later byte replaces an earlier byte at the same slot.

When chip select rises on a byte boundary and at least one granted byte is waiting, the block walks the page slots in ascending order. It issues one array write for each slot that holds a granted byte and leaves every other slot alone. It then runs the programming timer. A one-cycle done pulse marks the return to ready, and the surrounding logic uses it to clear the write-enable latch. A status-register programming request uses the same timer but makes no array write. While the block is busy, every new request is dropped.

Top module: `pgw_engine`

## Requirements
- R1: After reset, `busy`, `done` and `arrWe` are all 0.
- R2: An accepted byte goes to the page slot given by the low 6 bits of the running address. These bits start at `startAddr[5:0]` and advance by one per byte. The upper bits stay at `startAddr[12:6]` for every array write of that sequence.
- R3: After slot 63 the offset returns to slot 0 of the same page. A later byte written to a slot replaces the earlier byte, and the array receives only the last one.
- R4: No array write happens before the `csRise` that closes the sequence. `arrWe` is asserted only while `busy` is 1.
- R5: A `csRise` with `csAligned` low drops the whole sequence. No array write follows, `busy` stays 0 and no `done` pulse is issued.
- R6: A byte sent with `byteGrant` low is never written to the array. If no byte of the sequence was granted, `csRise` starts no cycle and `busy` stays 0.
- R7: The commit writes only the slots that received a granted byte. It writes them one per cycle in ascending offset order.
- R8: `busy` rises in the cycle after the accepted `csRise`. It stays 1 for exactly PAGE_BYTES + PROG_CYCLES cycles (64 + PROG_CYCLES).
- R9: `done` is a single-cycle pulse in the first cycle after `busy` falls.
- R10: While `busy` is 1, `startValid`, `byteValid`, `csRise` and `statusStart` have no effect on the array writes, on the busy length or on the state left behind. A `csRise` after the cycle has ended starts nothing.
- R11: `statusStart` while idle makes `busy` 1 from the next cycle for exactly PROG_CYCLES cycles, with no array write, and then pulses `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Opens a page write sequence at `startAddr` |
| startAddr | input | 13 | First byte address of the sequence |
| byteValid | input | 1 | One received data byte is present |
| byteData | input | 8 | Data byte |
| byteGrant | input | 1 | Protection arbiter permits this byte |
| csRise | input | 1 | Chip select rising event |
| csAligned | input | 1 | Chip select rose on a byte boundary |
| statusStart | input | 1 | Start a status-register programming interval |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | 13 | Array write address |
| arrData | output | 8 | Array write data |
| busy | output | 1 | Programming in progress (status ready bit) |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every input is driven at a falling clock edge, so `busy` is due at the very next falling edge after an accepted `csRise` or `statusStart`. The bench checks it there and then counts the falling edges that show `busy` high, comparing the count with 64 + PROG_CYCLES or with PROG_CYCLES. `done` is due at the first falling edge with `busy` low, and the bench checks that it is gone one edge later. Array writes are logged at falling edges, where the registered scan is steady. They are then compared, in order, with a page model that the bench builds from the bytes it sent.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2,
    ST_TIMER   = 2'd3
  } pgw_state_t;

  typedef struct packed {
    logic load;       // capture start address, clear slot mask
    logic accept;     // store one byte at current offset
    logic scanClear;  // reset commit scan pointer
    logic scanStep;   // commit scan active this cycle
  } pgw_strobe_t;

endpackage

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgw_strobe_t       strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        byteData,
  input  logic              byteGrant,
  output logic              maskAny,
  output logic              scanLast,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0]     pageQ;
  logic [OFS_W-1:0]      ofsQ;
  logic [OFS_W-1:0]      scanQ;
  logic [PAGE_BYTES-1:0] maskQ;
  logic [7:0]            dataBuf [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ <= '0;
      ofsQ  <= '0;
      maskQ <= '0;
    end else if (strobe.load) begin
      pageQ <= startAddr[ADDR_W-1:OFS_W];
      ofsQ  <= startAddr[OFS_W-1:0];
      maskQ <= '0;
    end else if (strobe.accept) begin
      maskQ[ofsQ] <= byteGrant;
      ofsQ        <= ofsQ + 1'b1;   // wraps inside the page
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) dataBuf[ofsQ] <= byteData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 scanQ <= '0;
    else if (strobe.scanClear) scanQ <= '0;
    else if (strobe.scanStep)  scanQ <= scanQ + 1'b1;
  end

  assign maskAny  = |maskQ;
  assign scanLast = (scanQ == OFS_W'(PAGE_BYTES - 1));
  assign arrWe    = strobe.scanStep & maskQ[scanQ];
  assign arrAddr  = {pageQ, scanQ};
  assign arrData  = dataBuf[scanQ];

endmodule

// File: rtl/pgw_control.sv
module pgw_control
  import pgw_pkg::*;
#(
  parameter int PROG_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        byteValid,
  input  logic        csRise,
  input  logic        csAligned,
  input  logic        statusStart,
  input  logic        maskAny,
  input  logic        scanLast,
  output pgw_strobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  pgw_state_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic doneQ;
  logic timerEnd;
  logic commitGo;

  assign timerEnd = (cntQ == CNT_W'(PROG_CYCLES - 1));
  assign commitGo = csRise & csAligned & maskAny;

  always_comb begin
    strobe = '0;
    unique case (stateQ)
      ST_IDLE:    strobe.load = startValid & ~statusStart;
      ST_COLLECT: begin
        if (csRise) begin
          strobe.scanClear = commitGo;
        end else begin
          strobe.load   = startValid;
          strobe.accept = byteValid & ~startValid;
        end
      end
      ST_COMMIT:  strobe.scanStep = 1'b1;
      default:    strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (statusStart) begin
            stateQ <= ST_TIMER;
            cntQ   <= '0;
          end else if (startValid) begin
            stateQ <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (csRise) stateQ <= commitGo ? ST_COMMIT : ST_IDLE;
        end
        ST_COMMIT: begin
          if (scanLast) begin
            stateQ <= ST_TIMER;
            cntQ   <= '0;
          end
        end
        default: begin
          if (timerEnd) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (stateQ == ST_COMMIT) || (stateQ == ST_TIMER);
  assign done = doneQ;

endmodule

// File: rtl/pgw_engine.sv
module pgw_engine
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              byteGrant,
  input  logic              csRise,
  input  logic              csAligned,
  input  logic              statusStart,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData,
  output logic              busy,
  output logic              done
);

  pgw_strobe_t strobe;
  logic maskAny;
  logic scanLast;

  pgw_control #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .byteValid(byteValid),
    .csRise(csRise), .csAligned(csAligned), .statusStart(statusStart),
    .maskAny(maskAny), .scanLast(scanLast),
    .strobe(strobe), .busy(busy), .done(done)
  );

  pgw_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startAddr(startAddr), .byteData(byteData), .byteGrant(byteGrant),
    .maskAny(maskAny), .scanLast(scanLast),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr,
  input logic              busy,
  input logic              done
);

  localparam int OFS_W   = $clog2(PAGE_BYTES);
  localparam int MAX_RUN = PAGE_BYTES + PROG_CYCLES;
  localparam int RUN_W   = $clog2(MAX_RUN + 2);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R4: array is touched only inside the busy interval
  assert_we_needs_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

  // R2: page bits do not move during one busy interval
  assert_page_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(arrAddr[ADDR_W-1:OFS_W]));

  // R7: back-to-back writes step to the next slot
  assert_ascending_R7: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && $past(arrWe) && $past(busy)) |-> (arrAddr == $past(arrAddr) + 1'b1));

  // R8: busy never outlasts the commit scan plus the timer
  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(MAX_RUN));

  // R9: done follows the busy interval and lasts one cycle
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind pgw_engine pgw_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_pgw_checker (
  .clk(clk), .rstN(rstN), .arrWe(arrWe), .arrAddr(arrAddr),
  .busy(busy), .done(done)
);

// File: tb/pgw_engine_bench.sv
module pgw_engine_bench;

  localparam int ADDR_W = 13;
  localparam int PAGE   = 64;
  localparam int PROG   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteGrant = 1'b0;
  logic csRise = 1'b0;
  logic csAligned = 1'b0;
  logic statusStart = 1'b0;
  logic arrWe;
  logic [ADDR_W-1:0] arrAddr;
  logic [7:0] arrData;
  logic busy;
  logic done;

  int checks = 0;
  int fails = 0;

  logic [ADDR_W-1:0] capAddr [128];
  logic [7:0]        capData [128];
  int capCount = 0;

  logic [7:0] expData [PAGE];
  logic       expMask [PAGE];
  logic [6:0] expPage;
  int         expOfs;

  always #10 clk = ~clk;

  pgw_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u_pgw_engine (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .byteGrant(byteGrant),
    .csRise(csRise), .csAligned(csAligned), .statusStart(statusStart),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData),
    .busy(busy), .done(done)
  );

  always @(negedge clk) begin
    if (arrWe && capCount < 128) begin
      capAddr[capCount] = arrAddr;
      capData[capCount] = arrData;
      capCount = capCount + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic sendStart(input logic [ADDR_W-1:0] a);
    startValid = 1'b1; startAddr = a;
    @(negedge clk);
    startValid = 1'b0;
    for (int i = 0; i < PAGE; i++) expMask[i] = 1'b0;
    expPage = a[12:6];
    expOfs  = int'(a[5:0]);
    capCount = 0;
  endtask

  task automatic sendByte(input logic [7:0] d, input logic g, input bit model);
    byteValid = 1'b1; byteData = d; byteGrant = g;
    @(negedge clk);
    byteValid = 1'b0;
    if (model) begin
      expData[expOfs] = d;
      expMask[expOfs] = g;
      expOfs = (expOfs + 1) % PAGE;
    end
  endtask

  task automatic pulseCs(input logic aligned);
    csRise = 1'b1; csAligned = aligned;
    @(negedge clk);
    csRise = 1'b0; csAligned = 1'b0;
  endtask

  // starts at the first negedge after the accepting edge
  task automatic measureBusy(input string tag, input int expLen);
    int len = 0;
    chk({tag, " busy rises next cycle"}, busy, 1);
    while (busy && len < 1000) begin
      len++;
      @(negedge clk);
    end
    chk({tag, " busy length"}, len, expLen);
    chk({tag, " done pulse"}, done, 1);
    @(negedge clk);
    chk({tag, " done single cycle"}, done, 0);
  endtask

  task automatic checkWrites(input string tag);
    int k = 0;
    for (int o = 0; o < PAGE; o++) begin
      if (expMask[o]) begin
        chk({tag, " write addr"}, capAddr[k], {expPage, 6'(o)});
        chk({tag, " write data"}, capData[k], expData[o]);
        k++;
      end
    end
    chk({tag, " write count"}, capCount, k);
  endtask

  task automatic quietFor(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      chk({tag, " stays idle"}, busy, 0);
      chk({tag, " no done"}, done, 0);
      @(negedge clk);
    end
    chk({tag, " no array write"}, capCount, 0);
  endtask

  task automatic tReset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 arrWe after reset", arrWe, 0);
  endtask

  task automatic tBasic();
    sendStart(13'h1A45);
    sendByte(8'hA1, 1, 1);
    sendByte(8'hA2, 1, 1);
    sendByte(8'hA3, 1, 1);
    @(negedge clk);
    chk("R4 no write before cs rise", capCount, 0);
    pulseCs(1);
    measureBusy("R8 basic", PAGE + PROG);
    checkWrites("R2 R7 basic");
  endtask

  task automatic tWrap();
    sendStart(13'd190);
    for (int i = 0; i < 66; i++) sendByte(8'(i + 16), 1, 1);
    pulseCs(1);
    measureBusy("R8 wrap", PAGE + PROG);
    checkWrites("R3 wrap overwrite");
    chk("R3 slot 62 last byte", expData[62], 8'd80);
  endtask

  task automatic tGrant();
    sendStart(13'h0802);
    sendByte(8'h11, 1, 1);
    sendByte(8'h22, 0, 1);
    sendByte(8'h33, 1, 1);
    sendByte(8'h44, 0, 1);
    pulseCs(1);
    measureBusy("R6 mixed grant", PAGE + PROG);
    checkWrites("R6 R7 granted only");
    chk("R6 two writes", capCount, 2);
  endtask

  task automatic tNoGrant();
    sendStart(13'h0100);
    sendByte(8'h55, 0, 1);
    sendByte(8'h66, 0, 1);
    pulseCs(1);
    quietFor("R6 nothing granted", 5);
  endtask

  task automatic tMisaligned();
    sendStart(13'h0300);
    sendByte(8'h77, 1, 1);
    sendByte(8'h88, 1, 1);
    pulseCs(0);
    quietFor("R5 misaligned cs", 5);
    pulseCs(1);
    quietFor("R5 later cs after drop", 3);
  endtask

  task automatic tIgnore();
    sendStart(13'h0A10);
    sendByte(8'hC1, 1, 1);
    sendByte(8'hC2, 1, 1);
    pulseCs(1);
    begin
      int len = 1;
      chk("R10 busy", busy, 1);
      startValid = 1'b1; startAddr = 13'h0A00;
      @(negedge clk); len++;
      startValid = 1'b0;
      for (int i = 0; i < 4; i++) begin
        byteValid = 1'b1; byteData = 8'hEE; byteGrant = 1'b1;
        @(negedge clk); len++;
      end
      byteValid = 1'b0;
      statusStart = 1'b1; csRise = 1'b1; csAligned = 1'b1;
      @(negedge clk); len++;
      statusStart = 1'b0; csRise = 1'b0; csAligned = 1'b0;
      while (busy && len < 1000) begin
        @(negedge clk);
        if (busy) len++;
      end
      chk("R10 busy length unchanged", len, PAGE + PROG);
      chk("R10 done", done, 1);
    end
    checkWrites("R10 writes unchanged");
    @(negedge clk);
    capCount = 0;
    pulseCs(1);
    quietFor("R10 no leftover sequence", 4);
  endtask

  task automatic tStatus();
    capCount = 0;
    statusStart = 1'b1;
    @(negedge clk);
    statusStart = 1'b0;
    measureBusy("R11 status timer", PROG);
    chk("R11 no array write", capCount, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tWrap();
    tGrant();
    tNoGrant();
    tMisaligned();
    tIgnore();
    tStatus();
    finishRun();
  end

endmodule